// File: doc/BRIEF.md
# Dual-Port Register File with Tri-State Read Bus

This block is a small array of words with one write port and one read port that work independently. In the same cycle one location can be written while another is read. Writes are clocked. Each rising edge with the active-low write strobe low stores the write data at the write address. While the strobe is low, a read of the location being written returns the incoming data at once, through a combinational bypass, so the port behaves as a transparent write.

The read port drives its data lines only while its active-low read enable is low. At all other times the lines float, so several instances can share one read bus. To make wider words, instances are placed side by side with common address and enable lines. To add more words, instances share the read bus and at most one of them has its read enable low at a time. The read address always selects a word, whatever state either enable is in.

A synchronous active-high reset clears every stored word. It has no effect on the read-enable control of the bus.

Top module: `regfile_dp`

## Requirements
- R1: A rising clock edge with `rst` high clears every stored word to zero, and this overrides any write in that cycle.
- R2: A rising clock edge with `rst` low and `wr_en_n` low stores `wr_data` into the word selected by `wr_addr`. No other word changes.
- R3: A rising clock edge with `wr_en_n` high leaves every stored word unchanged, whatever `wr_addr` and `wr_data` carry.
- R4: While `wr_en_n` is low and `rd_addr` equals `wr_addr`, an enabled read shows the present `wr_data` in the same cycle and follows changes to it, not the old contents.
- R5: While `rd_en_n` is low and no write-through applies, `rd_q` equals the stored word at `rd_addr`, bit for bit and not inverted.
- R6: While `rd_en_n` is high, all bits of `rd_q` are high impedance, so another driver on the bus sets its value.
- R7: A write to one address and a read of a different address in the same cycle both succeed. The read shows the old contents of its own address before and after the edge, and the written word is correct afterwards.
- R8: The word selected by `rd_addr` does not depend on either enable. An address applied while the read port is disabled is presented as soon as `rd_en_n` falls, with no clock edge in between.
- R9: Reset does not alter output enabling. While `rst` is high, `rd_q` floats when `rd_en_n` is high and is driven when `rd_en_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores on rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all words |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_addr | input | ADDR_W (2) | Word selected for writing |
| wr_data | input | WIDTH (4) | Data to store |
| rd_en_n | input | 1 | Read bus enable, active low |
| rd_addr | input | ADDR_W (2) | Word selected for reading |
| rd_q | output | WIDTH (4) | Read data; high impedance when disabled |

## Verification
The hardest state to observe from the ports is the floating bus. A two-state simulator cannot tell a released line from a driven zero. To get around this, the bench places its own driver on the same net and drives two complementary patterns while the read port is disabled. If the block still drives the net, at least one pattern is corrupted. Write-through is caught inside the cycle before the storing edge: the bench changes `wr_data` between two samples taken while the strobe is low, which separates a live bypass from a value captured earlier.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_DEF_WORDS = 4;
  parameter int unsigned RF_DEF_WIDTH = 4;

  function automatic int unsigned rf_addr_bits(input int unsigned words);
    return (words < 2) ? 1 : $clog2(words);
  endfunction
endpackage

// File: rtl/rf_word_bank.sv
module rf_word_bank #(
  parameter int unsigned WORDS  = rf_pkg::RF_DEF_WORDS,
  parameter int unsigned WIDTH  = rf_pkg::RF_DEF_WIDTH,
  parameter int unsigned ADDR_W = rf_pkg::rf_addr_bits(WORDS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_n,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [WORDS-1:0][WIDTH-1:0] words_q
);
  logic wr_go;
  assign wr_go = ~wr_en_n;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi);
    logic hit;
    assign hit = wr_go && (wr_addr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (rst)      words_q[gi] <= '0;
      else if (hit) words_q[gi] <= wr_data;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (words_q[gi] == '0));                                  // R1
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (!wr_en_n && wr_addr == MY_ADDR) |=> (words_q[gi] == $past(wr_data))); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      wr_en_n |=> $stable(words_q[gi]));                             // R3
  end
endmodule

// File: rtl/rf_read_path.sv
module rf_read_path #(
  parameter int unsigned WORDS  = rf_pkg::RF_DEF_WORDS,
  parameter int unsigned WIDTH  = rf_pkg::RF_DEF_WIDTH,
  parameter int unsigned ADDR_W = rf_pkg::rf_addr_bits(WORDS)
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words_q,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic                        wr_en_n,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [WIDTH-1:0]            stored_word,
  output logic [WIDTH-1:0]            rd_word
);
  logic bypass;

  always_comb begin
    stored_word = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (rd_addr == ADDR_W'(k)) stored_word = words_q[k];
    end
  end

  assign bypass  = ~wr_en_n && (rd_addr == wr_addr);
  assign rd_word = bypass ? wr_data : stored_word;
endmodule

// File: rtl/rf_bus_driver.sv
module rf_bus_driver #(
  parameter int unsigned WIDTH = rf_pkg::RF_DEF_WIDTH
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] bus
);
  assign bus = oe_n ? {WIDTH{1'bz}} : din;
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp #(
  parameter int unsigned WORDS  = rf_pkg::RF_DEF_WORDS,
  parameter int unsigned WIDTH  = rf_pkg::RF_DEF_WIDTH,
  parameter int unsigned ADDR_W = rf_pkg::rf_addr_bits(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_q
);
  logic [WORDS-1:0][WIDTH-1:0] words_q;
  logic [WIDTH-1:0]            stored_word;
  logic [WIDTH-1:0]            rd_word;

  rf_word_bank #(.WORDS(WORDS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en_n (wr_en_n),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .words_q (words_q)
  );

  rf_read_path #(.WORDS(WORDS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_read (
    .words_q     (words_q),
    .rd_addr     (rd_addr),
    .wr_en_n     (wr_en_n),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .stored_word (stored_word),
    .rd_word     (rd_word)
  );

  rf_bus_driver #(.WIDTH(WIDTH)) u_drv (
    .oe_n (rd_en_n),
    .din  (rd_word),
    .bus  (rd_q)
  );

  AST_THROUGH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_n && rd_addr == wr_addr) |-> (rd_word == wr_data));      // R4
  AST_TRUE_READ: assert property (@(posedge clk) disable iff (rst)
    (wr_en_n || rd_addr != wr_addr) |-> (rd_word == stored_word));   // R5
  AST_OTHER_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_n && rd_addr != wr_addr && $stable(rd_addr))
      |=> (stored_word == $past(stored_word)));                      // R7
endmodule

// File: tb/tb_regfile_dp.sv
module tb_regfile_dp;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4;
  localparam int WIDTH = 4;
  localparam int AW    = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             wr_en_n;
  logic [AW-1:0]    wr_addr;
  logic [WIDTH-1:0] wr_data;
  logic             rd_en_n;
  logic [AW-1:0]    rd_addr;
  wire  [WIDTH-1:0] bus;
  logic             tb_drv_en;
  logic [WIDTH-1:0] tb_drv_val;

  logic [WIDTH-1:0] model [WORDS];
  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  assign bus = tb_drv_en ? tb_drv_val : {WIDTH{1'bz}};

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_dp #(.WORDS(WORDS), .WIDTH(WIDTH)) dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en_n (wr_en_n),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en_n (rd_en_n),
    .rd_addr (rd_addr),
    .rd_q    (bus)
  );

  task automatic check(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic read_expect(input string tag, input logic [AW-1:0] a,
                             input logic [WIDTH-1:0] exp);
    rd_addr = a;
    rd_en_n = 1'b0;
    #1;
    check(tag, bus, exp);
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    wr_en_n = 1'b0; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en_n = 1'b1;
    model[a] = d;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; wr_en_n = 1'b0; wr_addr = 2'd1; wr_data = 4'hF;
    @(negedge clk);
    rst = 1'b0; wr_en_n = 1'b1;
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    for (int i = 0; i < WORDS; i++) read_expect("R1 reset clears", AW'(i), 4'h0);
  endtask

  task automatic t_write_read();
    logic [WIDTH-1:0] pats [4] = '{4'h5, 4'hA, 4'hC, 4'h3};
    for (int i = 0; i < WORDS; i++) write_word(AW'(i), pats[i]);
    for (int i = 0; i < WORDS; i++) read_expect("R2 stored word", AW'(i), model[i]);
    write_word(2'd2, 4'h9);
    for (int i = 0; i < WORDS; i++) read_expect("R5 true read", AW'(i), model[i]);
  endtask

  task automatic t_hold();
    @(negedge clk);
    wr_en_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      wr_addr = AW'(c); wr_data = ~model[c];
      @(negedge clk);
    end
    for (int i = 0; i < WORDS; i++) read_expect("R3 idle strobe holds", AW'(i), model[i]);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    wr_en_n = 1'b0; wr_addr = 2'd1; wr_data = 4'h6;
    read_expect("R4 write-through", 2'd1, 4'h6);
    wr_data = 4'hE;
    #1;
    check("R4 write-through follows data", bus, 4'hE);
    @(negedge clk);
    wr_en_n = 1'b1;
    model[1] = 4'hE;
    read_expect("R4 stored after strobe", 2'd1, 4'hE);
  endtask

  task automatic t_simul();
    @(negedge clk);
    wr_en_n = 1'b0; wr_addr = 2'd0; wr_data = 4'h7;
    read_expect("R7 other word before edge", 2'd3, model[3]);
    @(posedge clk);
    #1;
    check("R7 other word after edge", bus, model[3]);
    @(negedge clk);
    wr_en_n = 1'b1;
    model[0] = 4'h7;
    read_expect("R7 written word", 2'd0, 4'h7);
  endtask

  task automatic t_hiz();
    @(negedge clk);
    rd_en_n = 1'b1; tb_drv_en = 1'b1;
    tb_drv_val = 4'b1010; #1;
    check("R6 bus released pattern A", bus, 4'b1010);
    tb_drv_val = 4'b0101; #1;
    check("R6 bus released pattern B", bus, 4'b0101);
    tb_drv_en = 1'b0;
  endtask

  task automatic t_addr_indep();
    @(negedge clk);
    rd_en_n = 1'b1; wr_en_n = 1'b1;
    rd_addr = 2'd3;
    #2;
    rd_en_n = 1'b0; #1;
    check("R8 address applied while disabled", bus, model[3]);
    rd_en_n = 1'b1; rd_addr = 2'd0; #2;
    rd_en_n = 1'b0; #1;
    check("R8 second address", bus, model[0]);
  endtask

  task automatic t_reset_oe();
    @(negedge clk);
    rst = 1'b1; wr_en_n = 1'b1; rd_addr = 2'd3;
    rd_en_n = 1'b1; tb_drv_en = 1'b1;
    tb_drv_val = 4'b0011; #1;
    check("R9 floating in reset A", bus, 4'b0011);
    tb_drv_val = 4'b1100; #1;
    check("R9 floating in reset B", bus, 4'b1100);
    tb_drv_en = 1'b0;
    rd_en_n = 1'b0; #1;
    check("R9 driven in reset", bus, model[3]);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    read_expect("R1 cleared after second reset", 2'd3, 4'h0);
  endtask

  initial begin
    rst = 1'b1; wr_en_n = 1'b1; wr_addr = '0; wr_data = '0;
    rd_en_n = 1'b1; rd_addr = '0; tb_drv_en = 1'b0; tb_drv_val = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read();
    t_hold();
    t_bypass();
    t_simul();
    t_hiz();
    t_addr_indep();
    t_reset_oe();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule